// File: doc/BRIEF.md
# Floating-Point Result Rounder

This combinational block is the last stage of a single-precision arithmetic datapath. An upstream adder, multiplier or divider delivers a sign, a biased 8-bit exponent and a 24-bit significand that is already normalized and carries its hidden leading one. It also delivers two extra bits from below the last kept position: the first discarded bit (round) and the OR of everything beneath it (sticky). The rounder chooses whether to add one unit in the last place. The choice depends on the selected rounding mode, the sign, those two bits and the current last fraction bit. The block then packs the outcome into a 32-bit word.

If the increment ripples through a significand of all ones, the result is renormalized to 1.000… and the exponent goes up by one. If that pushes the exponent to its all-ones code, the output becomes a signed infinity and an overflow flag is raised. The mode input selects round to nearest (ties to even), round toward zero, round toward plus infinity or round toward minus infinity. Its value can change on every operation.

Top module: `fp_round_unit`

## Requirements
- R1: The output word holds the sign in bit 31, the exponent in bits 30:23 and the significand without its hidden bit in bits 22:0. When round and sticky are both 0, that word is the unmodified input in every mode.
- R2: Mode code 2'b00 (nearest, ties to even) adds one when round=1 and sticky=1. When round=1 and sticky=0 it adds one only if significand bit 0 is 1. When round=0 it truncates.
- R3: Mode code 2'b01 (toward zero) always truncates, whatever the sign, round and sticky values are.
- R4: Mode code 2'b10 (toward +infinity) adds one when the sign is 0 and round or sticky is 1. In every other case it truncates.
- R5: Mode code 2'b11 (toward -infinity) adds one when the sign is 1 and round or sticky is 1. In every other case it truncates.
- R6: An increment applied to a significand of all ones gives fraction 0 and the input exponent plus one.
- R7: When the exponent after rounding equals 255, the output is exponent 255 with fraction 0 and overflow_o is 1. In all other cases overflow_o is 0 and the exponent field is below 255.
- R8: The output sign bit always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the unrounded value (1 = negative) |
| exp_i | input | 8 | Biased exponent, 1 to 254 |
| sig_i | input | 24 | Normalized significand, hidden one in bit 23 |
| round_i | input | 1 | First bit below the last kept significand bit |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result_o | output | 32 | Rounded, packed single-precision word |
| overflow_o | output | 1 | Rounding pushed the exponent to 255; result is signed infinity |

## Verification
The sweep covers every mode against every sign and every round/sticky pair. The significands have both values of the last bit, so a tie-breaking rule that looks at the wrong bit, or that always rounds ties up, gives results off by one ulp. Swapped directed modes show up as increments on the wrong sign. All-ones significands are checked at ordinary exponents and at exponent 254. A missing renormalization would wrap the fraction to zero without bumping the exponent. A missing overflow test would emit an exponent of 255 with the wrong flag, or a wrapped exponent of 0.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic                   sign_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [SIG_W-1:0]       sig_i,
  input  logic                   round_i,
  input  logic                   sticky_i,
  input  logic [1:0]             mode_i,
  output logic [EXP_W+SIG_W-1:0] result_o,
  output logic                   overflow_o
);

  localparam int FRAC_W = SIG_W - 1;
  localparam logic [EXP_W-1:0] EXP_TOP = {EXP_W{1'b1}};

  logic             inexact;
  logic             bump;
  logic [SIG_W:0]   sum;
  logic             carry;
  logic [FRAC_W-1:0] frac_n;
  logic [EXP_W:0]   exp_n;

  assign inexact = round_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      2'b00:   bump = round_i & (sticky_i | sig_i[0]);
      2'b01:   bump = 1'b0;
      2'b10:   bump = ~sign_i & inexact;
      default: bump = sign_i & inexact;
    endcase
  end

  assign sum    = {1'b0, sig_i} + (SIG_W+1)'(bump);
  assign carry  = sum[SIG_W];
  assign frac_n = carry ? sum[SIG_W-1:1] : sum[FRAC_W-1:0];
  assign exp_n  = {1'b0, exp_i} + (EXP_W+1)'(carry);

  assign overflow_o = (exp_n >= {1'b0, EXP_TOP});
  assign result_o   = {sign_i,
                       overflow_o ? EXP_TOP : exp_n[EXP_W-1:0],
                       overflow_o ? {FRAC_W{1'b0}} : frac_n};

  always_comb begin
    assert_sign_kept_R8: assert (result_o[EXP_W+SIG_W-1] == sign_i);
    assert_ovf_is_inf_R7: assert (!overflow_o ||
      (result_o[EXP_W+FRAC_W-1:FRAC_W] == EXP_TOP && result_o[FRAC_W-1:0] == '0));
    assert_no_ovf_finite_R7: assert (overflow_o ||
      result_o[EXP_W+FRAC_W-1:FRAC_W] != EXP_TOP);
    assert_trunc_zero_R3: assert (mode_i != 2'b01 || exp_i == EXP_TOP ||
      result_o[EXP_W+FRAC_W-1:0] == {exp_i, sig_i[FRAC_W-1:0]});
    assert_exact_kept_R1: assert (inexact || exp_i == EXP_TOP ||
      result_o == {sign_i, exp_i, sig_i[FRAC_W-1:0]});
    assert_renorm_R6: assert (overflow_o ||
      result_o[EXP_W+FRAC_W-1:FRAC_W] == exp_i ||
      result_o[FRAC_W-1:0] == '0);
  end

endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sign_i = 1'b0;
  logic [7:0]  exp_i = 8'd0;
  logic [23:0] sig_i = 24'd0;
  logic        round_i = 1'b0;
  logic        sticky_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [31:0] result_o;
  logic        overflow_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fp_round_unit u_dut (
    .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i), .round_i(round_i),
    .sticky_i(sticky_i), .mode_i(mode_i), .result_o(result_o),
    .overflow_o(overflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] exp_res, input logic exp_ovf);
    checks++;
    if (result_o !== exp_res || overflow_o !== exp_ovf) begin
      fails++;
      $display("FAIL %s: mode=%b s=%b e=%0d sig=%h rs=%b%b got %h/%b expected %h/%b",
               req, mode_i, sign_i, exp_i, sig_i, round_i, sticky_i,
               result_o, overflow_o, exp_res, exp_ovf);
    end
  endtask

  function automatic string pick_req(input int md, input bit up, input bit wrapped, input bit ovf, input int rs);
    if (ovf) return "R7";
    if (wrapped) return "R6";
    if (rs == 0) return "R1";
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    logic [23:0] sigs [6];
    int          exps [4];
    sigs[0] = 24'h800000; sigs[1] = 24'h800001; sigs[2] = 24'hA5A5A4;
    sigs[3] = 24'hC00003; sigs[4] = 24'hFFFFFE; sigs[5] = 24'hFFFFFF;
    exps[0] = 1; exps[1] = 127; exps[2] = 253; exps[3] = 254;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0000_0000, 1'b0);

    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int rs = 0; rs < 4; rs++)
          for (int si = 0; si < 6; si++)
            for (int ei = 0; ei < 4; ei++) begin
              longint q;
              int     e;
              bit     up;
              bit     wrapped;
              bit     ovf;
              string  req;
              @(posedge clk);
              mode_i = md[1:0]; sign_i = sg[0]; round_i = rs[1]; sticky_i = rs[0];
              sig_i = sigs[si]; exp_i = exps[ei][7:0];
              // quarter-ulp remainder: R counts 2, S counts 1
              case (md)
                0: up = (rs == 3) || (rs == 2 && sigs[si][0]);
                1: up = 0;
                2: up = (sg == 0) && (rs != 0);
                default: up = (sg == 1) && (rs != 0);
              endcase
              q = longint'(sigs[si]) + (up ? 1 : 0);
              e = exps[ei];
              wrapped = 0;
              if (q == (64'd1 << 24)) begin
                q = 64'd1 << 23; e = e + 1; wrapped = 1;
              end
              ovf = (e >= 255);
              req = pick_req(md, up, wrapped, ovf, rs);
              @(negedge clk);
              if (ovf) check(req, {sg[0], 8'hFF, 23'd0}, 1'b1);
              else     check(req, {sg[0], e[7:0], q[22:0]}, 1'b0);
              // sign is always carried through unchanged (R8)
              checks++;
              if (result_o[31] !== sg[0]) begin
                fails++;
                $display("FAIL R8: sign got %b expected %b", result_o[31], sg[0]);
              end
            end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule